// File: doc/BRIEF.md
# Synthesizer Divider Pair Search

The block picks the feedback and reference divider settings for a frequency synthesizer that runs from a 14.31818 MHz reference. Software or a mode-set sequencer presents a target pixel frequency in units of 0.01 MHz and pulses `start_i`. The block first forces the target into the supported band. It then finds the power-of-two post-divider exponent by repeated doubling. Finally it walks through every reference divider value M and feedback divider value N, one pair per clock.

For each pair the block forms the synthesizer output in fixed point, scaled by 256. It compares that value with the target, which is scaled the same way, and keeps the pair with the smallest absolute error. When the walk ends, the block presents one packed 16-bit word that holds N, the exponent and M, and pulses `done_o` for one cycle. A target of zero skips the search and returns a fixed word at once.

Top module: `mn_search`

## Requirements
- R1: While reset is asserted and after it is released, `done_o` is 0 and `word_o` is 0x0000 until the first result.
- R2: A start with a target of zero makes `done_o` high on the next cycle with `word_o` = 0x00E0, and no search takes place.
- R3: A target below 8000 gives the same word as 8000. A target above 15938 gives the same word as 15938.
- R4: The exponent K starts at 0. While the working frequency is below 64000, the frequency doubles and K rises by one, one step per cycle. K appears in word bits 7:6.
- R5: The word names the pair with M in 2..30 and N in 35..247 that minimises |T − C|. Here T = clamped target × 256 / 100 and C = 938356 × (N+8) / (2^K × 256 × (M+2)), both divisions truncating.
- R6: M is the outer loop and N the inner loop, each ascending. A candidate replaces the kept pair only when its error is strictly smaller, so among equal errors the first pair visited wins.
- R7: The word is N×256 + K×64 + M, with N in bits 15:8, K in bits 7:6 and M in bits 5:0.
- R8: `done_o` is high for exactly one cycle per result. It rises K+1+6177 cycles after the start is sampled. `word_o` changes only in that cycle and holds between results.
- R9: Start pulses that arrive while a search is running are ignored, and the running search finishes with its own target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begins a search with the current target when idle |
| freq_i | input | 16 | Target frequency in 0.01 MHz units |
| word_o | output | 16 | Packed divider word {N, K, M} |
| done_o | output | 1 | One-cycle pulse when `word_o` carries a new result |

## Verification
The hardest case to reach from the ports is an exact tie, where two divider pairs give the same truncated candidate. The tie-breaking order only shows up in that situation. The stimulus uses target 8054, whose scaled value 20618 is hit exactly both by M=2, N=172 and by M=3, N=217. A search that kept the later pair would return a different word. A second start pulse during a running search, with a different target, shows whether the search is restarted or left alone.

// File: rtl/mn_search.sv
module mn_search #(
  parameter int unsigned FREQ_W     = 16,
  parameter int unsigned F_MIN      = 8000,
  parameter int unsigned F_MAX      = 15938,
  parameter int unsigned REF_SCALED = 938356,
  parameter int unsigned M_LO       = 2,
  parameter int unsigned M_HI       = 30,
  parameter int unsigned N_LO       = 35,
  parameter int unsigned N_HI       = 247,
  parameter int unsigned ZERO_WORD  = 32'h00E0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [FREQ_W-1:0] freq_i,
  output logic [15:0]       word_o,
  output logic              done_o
);

  localparam int unsigned M_W      = 6;
  localparam int unsigned N_W      = 8;
  localparam int unsigned K_W      = 2;
  localparam int unsigned WORK_LIM = F_MIN * 8;

  typedef enum logic [1:0] {S_IDLE, S_PREP, S_SRCH} state_t;
  state_t st;

  logic [31:0]    fcl, tgt_in, work, tgt, num, den, fout, err, best_err;
  logic [K_W-1:0] k;
  logic [M_W-1:0] m, best_m, pick_m;
  logic [N_W-1:0] n, best_n, pick_n;
  logic           better, last_n, last_pair;

  assign fcl = (32'(freq_i) < F_MIN) ? F_MIN :
               (32'(freq_i) > F_MAX) ? F_MAX : 32'(freq_i);
  assign tgt_in = (fcl << 8) / 32'd100;

  assign num  = REF_SCALED * (32'(n) + 32'd8);
  assign den  = (32'(m) + 32'd2) << (32'd8 + 32'(k));
  assign fout = num / den;
  assign err  = (tgt > fout) ? tgt - fout : fout - tgt;

  assign better    = err < best_err;
  assign last_n    = 32'(n) == N_HI;
  assign last_pair = last_n && (32'(m) == M_HI);
  assign pick_m    = better ? m : best_m;
  assign pick_n    = better ? n : best_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      done_o   <= 1'b0;
      word_o   <= '0;
      work     <= '0;
      tgt      <= '0;
      k        <= '0;
      m        <= M_W'(M_LO);
      n        <= N_W'(N_LO);
      best_m   <= M_W'(M_LO);
      best_n   <= N_W'(N_LO);
      best_err <= '1;
    end else begin
      done_o <= 1'b0;
      case (st)
        S_IDLE: if (start_i) begin
          if (freq_i == '0) begin
            word_o <= 16'(ZERO_WORD);
            done_o <= 1'b1;
          end else begin
            work     <= fcl;
            tgt      <= tgt_in;
            k        <= '0;
            m        <= M_W'(M_LO);
            n        <= N_W'(N_LO);
            best_m   <= M_W'(M_LO);
            best_n   <= N_W'(N_LO);
            best_err <= '1;
            st       <= S_PREP;
          end
        end
        S_PREP: begin
          if (work < WORK_LIM) begin
            work <= work << 1;
            k    <= k + K_W'(1);
          end else begin
            st <= S_SRCH;
          end
        end
        S_SRCH: begin
          if (better) begin
            best_err <= err;
            best_m   <= m;
            best_n   <= n;
          end
          if (last_pair) begin
            word_o <= 16'((32'(pick_n) << 8) + (32'(k) << 6) + 32'(pick_m));
            done_o <= 1'b1;
            st     <= S_IDLE;
          end else if (last_n) begin
            n <= N_W'(N_LO);
            m <= m + M_W'(1);
          end else begin
            n <= n + N_W'(1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mn_search_chk.sv
module mn_search_chk #(
  parameter int unsigned FREQ_W = 16,
  parameter int unsigned M_LO   = 2,
  parameter int unsigned M_HI   = 30,
  parameter int unsigned N_LO   = 35,
  parameter int unsigned N_HI   = 247
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [FREQ_W-1:0] freq,
  input logic              busy,
  input logic              done,
  input logic [15:0]       word
);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_word_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(word));

  p_zero_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && freq == '0) |=> (done && word == 16'h00E0));

  p_pair_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && word != 16'h00E0) |->
      (32'(word[5:0]) >= M_LO && 32'(word[5:0]) <= M_HI &&
       32'(word[15:8]) >= N_LO && 32'(word[15:8]) <= N_HI));

  p_no_early_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !done);

endmodule

bind mn_search mn_search_chk #(
  .FREQ_W(FREQ_W), .M_LO(M_LO), .M_HI(M_HI), .N_LO(N_LO), .N_HI(N_HI)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start_i), .freq(freq_i),
  .busy(st != S_IDLE), .done(done_o), .word(word_o)
);

// File: tb/mn_search_test.sv
module mn_search_test;

  localparam int PAIRS = (30 - 2 + 1) * (247 - 35 + 1);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] freq = '0;
  logic [15:0] word;
  logic        done;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  mn_search uut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .freq_i(freq),
    .word_o(word), .done_o(done)
  );

  function automatic int unsigned clampf(int unsigned f);
    if (f < 8000) return 8000;
    if (f > 15938) return 15938;
    return f;
  endfunction

  function automatic int ref_k(int unsigned f);
    int unsigned w = clampf(f);
    int kk = 0;
    while (w < 64000) begin
      w = w * 2;
      kk++;
    end
    return kk;
  endfunction

  function automatic logic [15:0] ref_word(int unsigned f);
    int unsigned t, c, e, be, bm, bn;
    int kk;
    if (f == 0) return 16'h00E0;
    t  = clampf(f) * 256 / 100;
    kk = ref_k(f);
    be = 32'hFFFF_FFFF;
    bm = 0;
    bn = 0;
    for (int mm = 2; mm <= 30; mm++)
      for (int nn = 35; nn <= 247; nn++) begin
        c = (938356 * (nn + 8)) / ((1 << kk) * 256 * (mm + 2));
        e = (t > c) ? t - c : c - t;
        if (e < be) begin
          be = e;
          bm = mm;
          bn = nn;
        end
      end
    return 16'(bn * 256 + kk * 64 + bm);
  endfunction

  bit          live = 0;
  bit          m_busy = 0;
  bit          m_done = 0;
  logic [15:0] m_word = '0;
  logic [15:0] pend = '0;
  int          cnt = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_word = '0; cnt = 0; live = 1;
    end else begin
      m_done = 0;
      if (m_busy) begin
        cnt--;
        if (cnt == 0) begin
          m_done = 1; m_word = pend; m_busy = 0;
        end
      end else if (start) begin
        if (freq == 0) begin
          m_done = 1; m_word = 16'h00E0;
        end else begin
          m_busy = 1;
          pend = ref_word(freq);
          cnt = ref_k(freq) + 1 + PAIRS;
        end
      end
    end
  end

  task automatic chk(bit ok, string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (live) begin
    chk(done == m_done, "R8 done pulse", {15'd0, done}, {15'd0, m_done});
    chk(word == m_word, "R7 word", word, m_word);
  end

  task automatic go(int unsigned f);
    @(negedge clk);
    start = 1'b1;
    freq  = 16'(f);
    @(negedge clk);
    start = 1'b0;
    while (m_busy) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] w_lo, w_hi;
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R1 done in reset", {15'd0, done}, 16'd0);
    chk(word == 16'h0, "R1 word in reset", word, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(word == 16'h0 && !done, "R1 after release", word, 16'h0);

    go(0);
    chk(done && word == 16'h00E0, "R2 zero target", word, 16'h00E0);

    go(8000);
    w_lo = word;
    chk(word == ref_word(8000), "R5 search 8000", word, ref_word(8000));
    chk(32'(word[7:6]) == ref_k(8000), "R4 exponent field", {14'd0, word[7:6]}, 16'(ref_k(8000)));

    go(5000);
    chk(word == w_lo, "R3 low clamp", word, w_lo);

    go(15938);
    w_hi = word;
    chk(word == ref_word(15938), "R5 search 15938", word, ref_word(15938));
    go(20000);
    chk(word == w_hi, "R3 high clamp", word, w_hi);

    go(12000);
    chk(word == ref_word(12000), "R5 search 12000", word, ref_word(12000));

    go(8054);
    chk(word == 16'hACC2, "R6 first tie kept", word, 16'hACC2);

    @(negedge clk);
    start = 1'b1; freq = 16'd9000;
    @(negedge clk);
    freq = 16'd14000;
    @(negedge clk);
    start = 1'b0;
    while (m_busy) @(negedge clk);
    chk(word == ref_word(9000), "R9 start ignored while busy", word, ref_word(9000));
    @(negedge clk);
    chk(!done && word == ref_word(9000), "R8 word held after pulse", word, ref_word(9000));

    repeat (4) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule